// File: doc/BRIEF.md
# SRAM Pattern Fill-and-Verify Tester

This block exercises an external asynchronous SRAM through a plain request/done memory port and reports whether every cell holds what was written. The electrical timing of the SRAM lives in a separate controller; this tester only issues one-location write and read requests and waits for each to be acknowledged.

A test consists of six phases. Each phase first writes one data pattern to every location in ascending address order, then reads every location back in the same order and compares. The uniform all-zeros and all-ones phases expose bits stuck at one level. The two address phases store each location's own low address bits (plain, then inverted), which exposes address lines that are shorted, open or swapped. The two alternating-bit phases expose coupling between neighbouring data bits. The first mismatch ends the run and freezes the failing address, the observed word and the expected word. A clean run through all six phases raises pass. A start pulse clears every result and begins again at the first phase and address zero, even while a run is in progress.

Top module: `sram_pattern_tester`

## Requirements
- R1: While reset is held and after its release, busy, pass, fail, mem_wr_req and mem_rd_req are low and the three failure fields read zero.
- R2: In the cycle after start is sampled high, busy and mem_wr_req are high, mem_addr is zero, and pass and fail are low, whatever the previous result was.
- R3: Within each phase, writes cover addresses 0 to DEPTH-1 in ascending order, and no read of that phase is issued before the last write of that phase is acknowledged.
- R4: Reads within a phase cover addresses 0 to DEPTH-1 in ascending order, each returned word being compared with that phase's expected value for the address.
- R5: The phases run in this fixed order with these values, where A is the address zero-extended or truncated to the data width: phase 0 all zeros (0x00), phase 1 all ones (0xFF), phase 2 A, phase 3 the bitwise inverse of A, phase 4 ones on odd bit positions (0xAA), phase 5 ones on even bit positions (0x55).
- R6: On the first mismatch, fail rises and busy falls in the cycle after the read acknowledge; fail_addr, fail_rdata and fail_expected hold the address, the returned word and the expected word; no further request is issued.
- R7: pass rises, together with busy falling, in the cycle after the last read of phase 5 is acknowledged without a mismatch; pass and fail are never high together, and neither is high while busy.
- R8: A request stays asserted with a stable address until its done input is seen high; exactly one access completes per cycle in which done and the matching request are both high; done inputs received while no request is pending have no effect on any output.
- R9: A start pulse arriving during a run, including in the same cycle as a mismatching read acknowledge, restarts the test at phase 0 address 0 and no failure is recorded for that read.
- R10: pass, fail and the failure fields stay unchanged after a run ends until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse: clear results, begin at phase 0 address 0 |
| mem_addr | output | AW = clog2(DEPTH) | Address of the current request |
| mem_wdata | output | DW | Write data of the current write request |
| mem_wr_req | output | 1 | Write request, held until acknowledged |
| mem_wr_done | input | 1 | Write acknowledge |
| mem_rd_req | output | 1 | Read request, held until acknowledged |
| mem_rd_done | input | 1 | Read acknowledge, mem_rdata valid with it |
| mem_rdata | input | DW | Read data |
| busy | output | 1 | A run is in progress |
| pass | output | 1 | All six phases completed without mismatch |
| fail | output | 1 | A mismatch stopped the run |
| fail_addr | output | AW | Address of the first mismatch |
| fail_rdata | output | DW | Word returned at that address |
| fail_expected | output | DW | Word that was expected there |

## Verification
The two functions that can coincide are the restart on start and the capture of a mismatch: a start pulse can land in exactly the cycle in which a read acknowledge delivers a wrong word. The bench injects a bit-coupling fault that is only visible in phase 4, counts acknowledged reads in its memory model, and raises start in the very cycle the first phase-4 read acknowledge is presented. It judges that the restart wins: the next cycle shows busy with a write to address 0 and fail low, and the repeated run later reports the same fault at phase 4 address 0.

// File: rtl/sram_tst_pkg.sv
package sram_tst_pkg;

  localparam int unsigned NUM_PHASES = 6;

  // Phase codes; the order is the test order.
  typedef enum logic [2:0] {
    PH_ZERO   = 3'd0,
    PH_ONES   = 3'd1,
    PH_ADDR   = 3'd2,
    PH_NADDR  = 3'd3,
    PH_ODD    = 3'd4,
    PH_EVEN   = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } state_e;

endpackage

// File: rtl/sram_tst_pat.sv
// Pattern generator: the value stored in (and expected from) one location.
module sram_tst_pat
  import sram_tst_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  phase_e          phase,
  input  logic [AW-1:0]   addr,
  output logic [DW-1:0]   value
);

  function automatic logic [DW-1:0] pattern_of(phase_e ph, logic [AW-1:0] a);
    logic [DW-1:0] lo;
    logic [DW-1:0] odd_ones;
    lo = DW'(a);
    odd_ones = '0;
    for (int i = 0; i < DW; i++) odd_ones[i] = i[0];
    case (ph)
      PH_ZERO:  return '0;
      PH_ONES:  return '1;
      PH_ADDR:  return lo;
      PH_NADDR: return ~lo;
      PH_ODD:   return odd_ones;
      default:  return ~odd_ones;
    endcase
  endfunction

  assign value = pattern_of(phase, addr);

endmodule

// File: rtl/sram_tst_walk.sv
// Address and phase counters.
module sram_tst_walk
  import sram_tst_pkg::*;
#(
  parameter int DEPTH = 32768,
  parameter int AW    = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv_addr,
  input  logic          adv_phase,
  output logic [AW-1:0] addr,
  output phase_e        phase,
  output logic          last_addr,
  output logic          last_phase
);

  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  assign last_addr  = (addr == TOP_ADDR);
  assign last_phase = (phase == phase_e'(NUM_PHASES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      addr  <= '0;
      phase <= PH_ZERO;
    end else begin
      if (adv_addr)  addr  <= last_addr ? '0 : addr + AW'(1);
      if (adv_phase) phase <= phase_e'(phase + 3'd1);
    end
  end

endmodule

// File: rtl/sram_tst_ctrl.sv
// Sequencing FSM, comparison and result latch.
module sram_tst_ctrl
  import sram_tst_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_done,
  input  logic          rd_done,
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] exp_data,
  input  logic [AW-1:0] addr,
  input  logic          last_addr,
  input  logic          last_phase,
  output logic          wr_req,
  output logic          rd_req,
  output logic          busy,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_rdata,
  output logic [DW-1:0] fail_expected,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic          miss,
  output logic          adv_addr,
  output logic          adv_phase
);

  state_e st;

  assign wr_req    = (st == ST_WRITE);
  assign rd_req    = (st == ST_READ);
  assign busy      = (st != ST_IDLE);
  assign wr_acc    = wr_req & wr_done;
  assign rd_acc    = rd_req & rd_done;
  assign miss      = rd_acc & (rdata != exp_data);
  assign adv_addr  = wr_acc | (rd_acc & ~miss);
  assign adv_phase = rd_acc & ~miss & last_addr & ~last_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      pass          <= 1'b0;
      fail          <= 1'b0;
      fail_addr     <= '0;
      fail_rdata    <= '0;
      fail_expected <= '0;
    end else if (start) begin
      st            <= ST_WRITE;
      pass          <= 1'b0;
      fail          <= 1'b0;
      fail_addr     <= '0;
      fail_rdata    <= '0;
      fail_expected <= '0;
    end else begin
      case (st)
        ST_WRITE: if (wr_acc && last_addr) st <= ST_READ;
        ST_READ: begin
          if (miss) begin
            st            <= ST_IDLE;
            fail          <= 1'b1;
            fail_addr     <= addr;
            fail_rdata    <= rdata;
            fail_expected <= exp_data;
          end else if (rd_acc && last_addr) begin
            if (last_phase) begin
              st   <= ST_IDLE;
              pass <= 1'b1;
            end else begin
              st <= ST_WRITE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_pattern_tester.sv
module sram_pattern_tester
  import sram_tst_pkg::*;
#(
  parameter  int DEPTH = 32768,
  parameter  int DW    = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wr_req,
  input  logic          mem_wr_done,
  output logic          mem_rd_req,
  input  logic          mem_rd_done,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          pass,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_rdata,
  output logic [DW-1:0] fail_expected
);

  // Internal events, named for the checker.
  phase_e        cur_phase;
  logic [DW-1:0] exp_data;
  logic          last_addr;
  logic          last_phase;
  logic          wr_acc;
  logic          rd_acc;
  logic          miss;
  logic          adv_addr;
  logic          adv_phase;

  sram_tst_walk #(.DEPTH(DEPTH), .AW(AW)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start),
    .adv_addr   (adv_addr),
    .adv_phase  (adv_phase),
    .addr       (mem_addr),
    .phase      (cur_phase),
    .last_addr  (last_addr),
    .last_phase (last_phase)
  );

  sram_tst_pat #(.AW(AW), .DW(DW)) u_pat (
    .phase (cur_phase),
    .addr  (mem_addr),
    .value (exp_data)
  );

  sram_tst_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .wr_done       (mem_wr_done),
    .rd_done       (mem_rd_done),
    .rdata         (mem_rdata),
    .exp_data      (exp_data),
    .addr          (mem_addr),
    .last_addr     (last_addr),
    .last_phase    (last_phase),
    .wr_req        (mem_wr_req),
    .rd_req        (mem_rd_req),
    .busy          (busy),
    .pass          (pass),
    .fail          (fail),
    .fail_addr     (fail_addr),
    .fail_rdata    (fail_rdata),
    .fail_expected (fail_expected),
    .wr_acc        (wr_acc),
    .rd_acc        (rd_acc),
    .miss          (miss),
    .adv_addr      (adv_addr),
    .adv_phase     (adv_phase)
  );

  // Write data is the pattern of the location being addressed.
  assign mem_wdata = exp_data;

endmodule

// File: rtl/sram_tst_chk.sv
module sram_tst_chk #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] mem_addr,
  input logic          mem_wr_req,
  input logic          mem_wr_done,
  input logic          mem_rd_req,
  input logic          mem_rd_done,
  input logic          busy,
  input logic          pass,
  input logic          fail,
  input logic [AW-1:0] fail_addr,
  input logic [DW-1:0] fail_rdata,
  input logic [DW-1:0] fail_expected,
  input logic          rd_acc,
  input logic          miss,
  input logic          last_addr
);

  p_req_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_req && mem_rd_req));

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_done && !start) |=> (mem_wr_req && $stable(mem_addr)));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_done && !start) |=> (mem_rd_req && $stable(mem_addr)));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && mem_wr_req && mem_addr == '0 && !pass && !fail));

  p_verdict_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!pass && !fail));

  p_pass_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && $rose(pass)) |-> ($past(rd_acc) && $past(last_addr)));

  p_miss_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !start) |=> (fail && !busy && fail_addr == $past(mem_addr)));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_wr_req && !mem_rd_req));

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(pass) && $stable(fail) && $stable(fail_addr)
                           && $stable(fail_rdata) && $stable(fail_expected)));

endmodule

bind sram_pattern_tester sram_tst_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .mem_addr      (mem_addr),
  .mem_wr_req    (mem_wr_req),
  .mem_wr_done   (mem_wr_done),
  .mem_rd_req    (mem_rd_req),
  .mem_rd_done   (mem_rd_done),
  .busy          (busy),
  .pass          (pass),
  .fail          (fail),
  .fail_addr     (fail_addr),
  .fail_rdata    (fail_rdata),
  .fail_expected (fail_expected),
  .rd_acc        (rd_acc),
  .miss          (miss),
  .last_addr     (last_addr)
);

// File: tb/sim_sram_pattern_tester.sv
`timescale 1ns/1ps
module sim_sram_pattern_tester;

  localparam int D  = 16;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_wr_req, mem_wr_done, mem_rd_req, mem_rd_done;
  logic [DW-1:0] mem_rdata;
  logic          busy, pass, fail;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_rdata, fail_expected;

  always #2.5 clk = ~clk;

  sram_pattern_tester #(.DEPTH(D), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr_req(mem_wr_req), .mem_wr_done(mem_wr_done),
    .mem_rd_req(mem_rd_req), .mem_rd_done(mem_rd_done),
    .mem_rdata(mem_rdata), .busy(busy), .pass(pass), .fail(fail),
    .fail_addr(fail_addr), .fail_rdata(fail_rdata), .fail_expected(fail_expected)
  );

  int nvec = 0;
  int nmiss = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nmiss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- faulty memory model ----------------
  logic [7:0] s0_m = '0, s1_m = '0;
  logic [3:0] f_addr = '0, a_mask = '0;
  logic       couple = 1'b0;
  logic       spur = 1'b0;
  logic [7:0] mem [D];
  logic       wd_m, rd_m;
  logic [7:0] rdat;

  assign mem_wr_done = wd_m | spur;
  assign mem_rd_done = rd_m | spur;
  assign mem_rdata   = rdat;

  always @(posedge clk) begin
    if (!rst_n) begin
      wd_m <= 1'b0;
      rd_m <= 1'b0;
      rdat <= '0;
    end else begin
      wd_m <= mem_wr_req && !wd_m;
      if (mem_wr_req && !wd_m)
        mem[mem_addr & ~a_mask] <= couple ? {mem_wdata[6], mem_wdata[6:0]} : mem_wdata;
      rd_m <= mem_rd_req && !rd_m;
      if (mem_rd_req && !rd_m) begin
        if (mem_addr == f_addr)
          rdat <= (mem[mem_addr & ~a_mask] & ~s0_m) | s1_m;
        else
          rdat <= mem[mem_addr & ~a_mask];
      end
    end
  end

  // ---------------- independent pattern and order monitor ----------------
  function automatic logic [7:0] bpat(int ph, int a);
    case (ph)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'(a);
      3: return ~8'(a);
      4: return 8'hAA;
      default: return 8'h55;
    endcase
  endfunction

  int wcnt = 0;
  int rcnt = 0;

  always @(negedge clk) begin
    #1;
    if (!rst_n || start) begin
      wcnt = 0;
      rcnt = 0;
    end else begin
      if (mem_wr_req && mem_wr_done) begin
        // R3 ascending write order, R5 write data per phase
        chk(mem_addr == 4'(wcnt % D) && mem_wdata == bpat(wcnt / D, wcnt % D),
            "R3/R5 write addr|data", {mem_addr, mem_wdata},
            {4'(wcnt % D), bpat(wcnt / D, wcnt % D)});
        wcnt++;
      end
      if (mem_rd_req && mem_rd_done) begin
        // R4 ascending reads; R3 all writes of the phase done first
        chk(mem_addr == 4'(rcnt % D) && wcnt == (rcnt / D + 1) * D,
            "R4/R3 read order", {mem_addr, 28'(wcnt)},
            {4'(rcnt % D), 28'((rcnt / D + 1) * D)});
        rcnt++;
      end
    end
  end

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [7:0] s0;
    logic [7:0] s1;
    logic [3:0] fa;
    logic [3:0] am;
    logic       cp;
    logic       xfail;
    logic [3:0] xaddr;
    logic [7:0] xrd;
    logic [7:0] xexp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h00, 4'd0,  4'h0, 1'b0, 1'b0, 4'd0,  8'h00, 8'h00},  // clean: pass
    '{8'h08, 8'h00, 4'd5,  4'h0, 1'b0, 1'b1, 4'd5,  8'hF7, 8'hFF},  // stuck low, ones phase
    '{8'h00, 8'h01, 4'd2,  4'h0, 1'b0, 1'b1, 4'd2,  8'h01, 8'h00},  // stuck high, zero phase
    '{8'h00, 8'h00, 4'd0,  4'h4, 1'b0, 1'b1, 4'd0,  8'h04, 8'h00},  // address bit 2 open: address phase
    '{8'h00, 8'h00, 4'd0,  4'h0, 1'b1, 1'b1, 4'd0,  8'h2A, 8'hAA},  // bit coupling: 0xAA phase
    '{8'h00, 8'h80, 4'd15, 4'h0, 1'b0, 1'b1, 4'd15, 8'h80, 8'h00},  // last address
    '{8'h01, 8'h00, 4'd0,  4'h0, 1'b0, 1'b1, 4'd0,  8'hFE, 8'hFF}   // first address, ones phase
  };

  task automatic load_fault(input vec_t v);
    s0_m = v.s0; s1_m = v.s1; f_addr = v.fa; a_mask = v.am; couple = v.cp;
  endtask

  task automatic pulse_start_and_check(input string tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(busy && mem_wr_req && !mem_rd_req && mem_addr == 4'd0 && !pass && !fail,
        tag, {busy, mem_wr_req, mem_addr, pass, fail}, {1'b1, 1'b1, 4'd0, 1'b0, 1'b0});
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    #1;
  endtask

  task automatic check_result(input vec_t v, input string tag);
    chk(!busy && pass == !v.xfail && fail == v.xfail, {tag, " R6/R7 verdict"},
        {busy, pass, fail}, {1'b0, !v.xfail, v.xfail});
    chk(fail_addr == v.xaddr && fail_rdata == v.xrd && fail_expected == v.xexp,
        {tag, " R6 captured fields"}, {fail_addr, fail_rdata, fail_expected},
        {v.xaddr, v.xrd, v.xexp});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    nmiss++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmiss);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !pass && !fail && !mem_wr_req && !mem_rd_req, "R1 in reset",
        {busy, pass, fail, mem_wr_req, mem_rd_req}, 5'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!busy && !pass && !fail && !mem_wr_req && !mem_rd_req &&
        fail_addr == 0 && fail_rdata == 0 && fail_expected == 0, "R1 after reset",
        {busy, pass, fail, fail_addr, fail_rdata, fail_expected}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load_fault(VEC[i]);
      pulse_start_and_check("R2 start clears status");
      wait_idle();
      check_result(VEC[i], "table");
      // R8/R10: stray acknowledges while idle change nothing
      @(negedge clk);
      spur = 1'b1;
      repeat (4) @(negedge clk);
      spur = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(!mem_wr_req && !mem_rd_req && !busy, "R8 stray done ignored",
          {mem_wr_req, mem_rd_req, busy}, 3'b0);
      check_result(VEC[i], "R10 hold");
    end

    // R9: start in the same cycle as a mismatching read acknowledge
    @(negedge clk);
    load_fault(VEC[4]);
    pulse_start_and_check("R2 start before R9");
    begin
      int n = 0;
      while (!(rcnt == 4 * D && mem_rd_req && mem_rd_done) && n < 5000) begin
        @(negedge clk);
        n++;
      end
    end
    start = 1'b1;  // coincides with the acknowledge of the first 0xAA read
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(!fail && busy && mem_wr_req && mem_addr == 4'd0, "R9 start wins over mismatch",
        {fail, busy, mem_wr_req, mem_addr}, {1'b0, 1'b1, 1'b1, 4'd0});
    wait_idle();
    check_result(VEC[4], "R9 rerun");

    // R9: restart of a clean run mid-write, then complete to pass
    @(negedge clk);
    load_fault(VEC[0]);
    pulse_start_and_check("R2 clean start");
    repeat (9) @(negedge clk);
    pulse_start_and_check("R9 restart mid-write");
    wait_idle();
    check_result(VEC[0], "R9 clean after restart");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmiss);
    $finish;
  end

endmodule